// File: doc/BRIEF.md
# Configuration Command Stream Sequencer

The sequencer walks a table of configuration commands held in a word-addressed ROM and turns it into register traffic on a single-beat memory-mapped master port. Every stored word is big-endian and is byte-swapped as it is fetched. The table opens with a header word that gives the table size. Commands follow, and each one carries its own byte length. A write command lists address/value pairs and applies each value by plain store, by clearing bits or by setting bits. A check command polls one register against a mask until a condition holds, and it can carry a retry budget. A no-op command does nothing.

A one-cycle `start` pulse, taken only while the block is idle, begins parsing at ROM offset 0. Parsing ends in one of two ways. The block raises a one-cycle `done` pulse once the parsed byte count equals the header length. Or it stops at the first fault and holds `error`, a fault code and the byte offset of the offending word until the next `start`. Any target address outside the fixed allowed windows is refused before it reaches the bus.

Both ports use a valid/ready handshake. A request is held, with address and data stable, until the cycle in which ready is high. That cycle completes the access, and ROM data or bus read data is taken in that same cycle. The block never has a ROM fetch and a bus access open together, and it never issues more than one bus access at a time. A slow ROM or a slow target only stalls the sequence. Nothing is lost.

Top module: `cfg_cmd_seq`

## Requirements
- R1: Each ROM word is used after a byte swap: stored bits 7:0 become value bits 31:24, 15:8 become 23:16, 23:16 become 15:8, and 31:24 become 7:0.
- R2: The header (word 0) must carry 0xD2 in bits 31:24 and 0x40 in bits 7:0, and its length in bits 23:8 must be a multiple of 4 from 4 to 1768. Any other header gives error code 2 at offset 0 with no bus access. A length of 4 is accepted and gives `done` with no bus access.
- R3: A write command (tag 0xCC in bits 31:24, length in bits 23:8 equal to 4 + 8·pairs, size in bits 2:0) with operation 0 in bits 7:3 issues one bus write per pair, in table order. Each write carries the pair's address and value, and `bus_size` equals the size field.
- R4: Operation 1 (clear) and operation 3 (set) perform a bus read and then a bus write to the same address. The written value is read AND NOT value for clear and read OR value for set. Operation values other than 0, 1 and 3 give error code 2 at the command offset.
- R5: A check command (tag 0xCF, length 12 or 16) polls its address with bus reads until the condition holds. Flag bit 3 set means any masked bit, and clear means all masked bits. Flag bit 4 set means the bits must be 1, and clear means they must be 0. Bits 7:5 must be zero.
- R6: A check of length 16 takes its fourth word as a poll budget N. After N failed polls (at least one poll) it stops with error code 3 at the command offset. A check of length 12 polls with no limit.
- R7: A no-op (tag 0xC0, length 4, low byte 0) makes no bus access.
- R8: A write or check address must lie inside one of these inclusive windows: 0x53FA8000–0x53FABFFF, 0x53FD4000–0x53FD7FFF, 0x63F80000–0x63F8FFFF, 0x63FD8000–0x63FD9FFF, 0x63FDA000–0x63FDAFFF, 0x70000000–0xEFFFFFFF, 0xF0000000–0xF7FFFFFF, 0xF8006000–0xF8017FF0, 0xF8020000–0xF805FFFF. Any other address gives error code 1 at the byte offset of that address word, with no access to it. Accesses earlier in the table are kept.
- R9: An unknown tag, a malformed length, a bad size (not 1, 2 or 4), or a command that would run past the header length gives error code 2 at the command offset, with no bus access for that command.
- R10: `done` is a one-cycle pulse and is never high together with `error`. `start` while idle sets `busy` in the next cycle and clears `error`, `err_code` and `err_off`.
- R11: A pending request keeps its valid, address, data and direction until ready. ROM fetches and bus accesses never overlap, and `error` holds both ports idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin parsing at offset 0 (ignored while busy) |
| busy | output | 1 | Parsing in progress |
| done | output | 1 | One-cycle pulse: whole table executed |
| error | output | 1 | Held fault flag |
| err_code | output | 2 | 1 bad address, 2 bad format, 3 poll timeout |
| err_off | output | 16 | Byte offset of the offending word |
| rom_valid | output | 1 | ROM fetch request |
| rom_ready | input | 1 | ROM fetch completes this cycle |
| rom_addr | output | ROM_AW | ROM word index |
| rom_data | input | 32 | Stored (big-endian) ROM word |
| bus_valid | output | 1 | Bus access request |
| bus_ready | input | 1 | Bus access completes this cycle |
| bus_write | output | 1 | 1 write, 0 read |
| bus_size | output | 3 | Access size field of the command |
| bus_addr | output | 32 | Target address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, taken in the ready cycle |

## Verification
Every result is registered. `done` and `error` appear in the cycle after the handshake that ends the table or exposes the fault, and a bus access appears in the cycle after the ROM handshake that completes its operands. The bench does not count cycles to those events. It samples on falling edges and waits for `done` or `error`. It then checks that `done` drops at the next falling edge, and it compares the bus transactions, which are logged at the handshake edges, against values worked out from the table. The ROM and the target stall on fixed patterns, so the hold-until-ready rules are exercised on every command.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam logic [7:0] TAG_HDR = 8'hD2;
  localparam logic [7:0] TAG_WR  = 8'hCC;
  localparam logic [7:0] TAG_CHK = 8'hCF;
  localparam logic [7:0] TAG_NOP = 8'hC0;
  localparam logic [7:0] HDR_VER = 8'h40;

  localparam int N_WIN = 9;
  localparam logic [31:0] WIN_LO [N_WIN] = '{
    32'h53FA8000, 32'h53FD4000, 32'h63F80000, 32'h63FD8000, 32'h63FDA000,
    32'h70000000, 32'hF0000000, 32'hF8006000, 32'hF8020000};
  localparam logic [31:0] WIN_HI [N_WIN] = '{
    32'h53FABFFF, 32'h53FD7FFF, 32'h63F8FFFF, 32'h63FD9FFF, 32'h63FDAFFF,
    32'hEFFFFFFF, 32'hF7FFFFFF, 32'hF8017FF0, 32'hF805FFFF};

  typedef enum logic [1:0] {K_NOP, K_WR, K_CHK, K_BAD} cmd_kind_t;
  typedef enum logic [1:0] {E_NONE, E_ADDR, E_FMT, E_TMO} err_t;
  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_CMD, S_WADDR, S_WVAL, S_CADDR, S_CMASK, S_CCNT, S_RD, S_WR
  } seq_state_t;

  function automatic logic [31:0] swap32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

endpackage

// File: rtl/cfg_addr_filter.sv
module cfg_addr_filter
  import cfg_seq_pkg::*;
(
  input  logic [31:0] addr,
  output logic        legal
);
  logic [N_WIN-1:0] hit;

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    assign hit[i] = (addr >= WIN_LO[i]) && (addr <= WIN_HI[i]);
  end

  assign legal = |hit;
endmodule

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [31:0]      word,
  input  logic [LEN_W-1:0] off,
  input  logic [LEN_W-1:0] tbl_len,
  output cmd_kind_t        kind,
  output logic [LEN_W-1:0] clen
);
  logic [15:0]    raw_len;
  logic [2:0]     size;
  logic [4:0]     fl;
  logic [LEN_W:0] end_sum;
  logic           fits, size_ok, wr_ok, chk_ok, nop_ok;

  assign raw_len = word[23:8];
  assign clen    = LEN_W'(raw_len);
  assign size    = word[2:0];
  assign fl      = word[7:3];
  assign end_sum = {1'b0, off} + {1'b0, clen};
  assign fits    = end_sum <= {1'b0, tbl_len};
  assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);

  assign nop_ok = (raw_len == 16'd4) && (word[7:0] == 8'h00);
  assign wr_ok  = (raw_len >= 16'd4) && (raw_len[2:0] == 3'd4) && size_ok &&
                  ((fl == 5'd0) || (fl == 5'd1) || (fl == 5'd3));
  assign chk_ok = ((raw_len == 16'd12) || (raw_len == 16'd16)) && size_ok &&
                  (fl[4:2] == 3'd0);

  always_comb begin
    kind = K_BAD;
    if (fits) begin
      unique case (word[31:24])
        TAG_NOP: kind = nop_ok ? K_NOP : K_BAD;
        TAG_WR:  kind = wr_ok  ? K_WR  : K_BAD;
        TAG_CHK: kind = chk_ok ? K_CHK : K_BAD;
        default: kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/cfg_poll_eval.sv
module cfg_poll_eval (
  input  logic [31:0] rdata,
  input  logic [31:0] mask,
  input  logic        any_bit,
  input  logic        want_set,
  output logic        hit
);
  logic [31:0] match;

  assign match = want_set ? (rdata & mask) : (~rdata & mask);
  assign hit   = any_bit ? (match != 32'd0) : (match == mask);
endmodule

// File: rtl/cfg_rmw.sv
module cfg_rmw (
  input  logic [31:0] rd,
  input  logic [31:0] val,
  input  logic [1:0]  op,
  output logic [31:0] wd
);
  always_comb begin
    unique case (op)
      2'b01:   wd = rd & ~val;
      2'b11:   wd = rd | val;
      default: wd = val;
    endcase
  end
endmodule

// File: rtl/cfg_cmd_seq.sv
module cfg_cmd_seq
  import cfg_seq_pkg::*;
#(
  parameter int ROM_AW  = 9,
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 1768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [1:0]        err_code,
  output logic [LEN_W-1:0]  err_off,
  output logic              rom_valid,
  input  logic              rom_ready,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [31:0]       rom_data,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [2:0]        bus_size,
  output logic [31:0]       bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(4);
  localparam logic [15:0]      LMAX = 16'(MAX_LEN);

  seq_state_t       state;
  logic [LEN_W-1:0] off, tbl_len, cmd_off, cmd_end;
  logic [1:0]       op;
  logic             chk_any, chk_set, has_cnt, is_chk;
  logic [2:0]       size_q;
  logic [31:0]      addr_q, val_q, cnt_q;
  logic             done_q, err_q;
  err_t             code_q;
  logic [LEN_W-1:0] eoff_q;

  logic [31:0]      w;
  logic             rom_hs, bus_hs, legal, hit, hdr_ok;
  logic [15:0]      hdr_len;
  cmd_kind_t        kind;
  logic [LEN_W-1:0] clen, off_nx;
  logic [31:0]      rmw_wd;

  assign w       = swap32(rom_data);
  assign rom_hs  = rom_valid && rom_ready;
  assign bus_hs  = bus_valid && bus_ready;
  assign off_nx  = off + STEP;
  assign hdr_len = w[23:8];
  assign hdr_ok  = (w[31:24] == TAG_HDR) && (w[7:0] == HDR_VER) &&
                   (hdr_len >= 16'd4) && (hdr_len <= LMAX) && (hdr_len[1:0] == 2'b00);

  cfg_addr_filter u_filt (.addr(w), .legal(legal));

  cfg_cmd_decode #(.LEN_W(LEN_W)) u_dec (
    .word(w), .off(off), .tbl_len(tbl_len), .kind(kind), .clen(clen));

  cfg_poll_eval u_poll (
    .rdata(bus_rdata), .mask(val_q), .any_bit(chk_any), .want_set(chk_set), .hit(hit));

  cfg_rmw u_rmw (.rd(bus_rdata), .val(val_q), .op(op), .wd(rmw_wd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      off     <= '0;
      tbl_len <= '0;
      cmd_off <= '0;
      cmd_end <= '0;
      op      <= 2'b00;
      chk_any <= 1'b0;
      chk_set <= 1'b0;
      has_cnt <= 1'b0;
      is_chk  <= 1'b0;
      size_q  <= 3'd0;
      addr_q  <= '0;
      val_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= E_NONE;
      eoff_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state  <= S_HDR;
          off    <= '0;
          err_q  <= 1'b0;
          code_q <= E_NONE;
          eoff_q <= '0;
        end
        S_HDR: if (rom_hs) begin
          if (!hdr_ok) begin
            state <= S_IDLE; err_q <= 1'b1; code_q <= E_FMT; eoff_q <= '0;
          end else begin
            tbl_len <= LEN_W'(hdr_len);
            off     <= STEP;
            if (hdr_len == 16'd4) begin
              state <= S_IDLE; done_q <= 1'b1;
            end else begin
              state <= S_CMD;
            end
          end
        end
        S_CMD: if (rom_hs) begin
          cmd_off <= off;
          cmd_end <= off + clen;
          off     <= off_nx;
          size_q  <= w[2:0];
          op      <= w[4:3];
          chk_any <= w[3];
          chk_set <= w[4];
          has_cnt <= (clen == LEN_W'(16));
          is_chk  <= (kind == K_CHK);
          unique case (kind)
            K_BAD: begin
              state <= S_IDLE; err_q <= 1'b1; code_q <= E_FMT; eoff_q <= off;
            end
            K_CHK: state <= S_CADDR;
            K_WR:  if (clen != STEP) state <= S_WADDR;
                   else if (off_nx == tbl_len) begin state <= S_IDLE; done_q <= 1'b1; end
                   else state <= S_CMD;
            default: if (off_nx == tbl_len) begin state <= S_IDLE; done_q <= 1'b1; end
                     else state <= S_CMD;
          endcase
        end
        S_WADDR, S_CADDR: if (rom_hs) begin
          if (!legal) begin
            state <= S_IDLE; err_q <= 1'b1; code_q <= E_ADDR; eoff_q <= off;
          end else begin
            addr_q <= w;
            off    <= off_nx;
            state  <= (state == S_WADDR) ? S_WVAL : S_CMASK;
          end
        end
        S_WVAL: if (rom_hs) begin
          val_q <= w;
          off   <= off_nx;
          state <= (op == 2'b00) ? S_WR : S_RD;
        end
        S_CMASK: if (rom_hs) begin
          val_q <= w;
          off   <= off_nx;
          state <= has_cnt ? S_CCNT : S_RD;
        end
        S_CCNT: if (rom_hs) begin
          cnt_q <= w;
          off   <= off_nx;
          state <= S_RD;
        end
        S_RD: if (bus_hs) begin
          if (!is_chk) begin
            val_q <= rmw_wd;
            state <= S_WR;
          end else if (hit) begin
            if (off == tbl_len) begin state <= S_IDLE; done_q <= 1'b1; end
            else state <= S_CMD;
          end else if (has_cnt) begin
            if (cnt_q <= 32'd1) begin
              state <= S_IDLE; err_q <= 1'b1; code_q <= E_TMO; eoff_q <= cmd_off;
            end else begin
              cnt_q <= cnt_q - 32'd1;
            end
          end
        end
        S_WR: if (bus_hs) begin
          if (off != cmd_end) state <= S_WADDR;
          else if (off == tbl_len) begin state <= S_IDLE; done_q <= 1'b1; end
          else state <= S_CMD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign err_code  = code_q;
  assign err_off   = eoff_q;
  assign rom_valid = (state == S_HDR) || (state == S_CMD) || (state == S_WADDR) ||
                     (state == S_WVAL) || (state == S_CADDR) || (state == S_CMASK) ||
                     (state == S_CCNT);
  assign rom_addr  = off[ROM_AW+1:2];
  assign bus_valid = (state == S_RD) || (state == S_WR);
  assign bus_write = (state == S_WR);
  assign bus_size  = size_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = val_q;
endmodule

// File: rtl/cfg_cmd_seq_chk.sv
module cfg_cmd_seq_chk #(
  parameter int ROM_AW = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              rom_valid,
  input logic              rom_ready,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [31:0]       bus_addr,
  input logic [31:0]       bus_wdata
);
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_valid && bus_valid));

  p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
                                $stable(bus_wdata) && $stable(bus_write));

  p_rom_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rom_valid && !rom_ready |=> rom_valid && $stable(rom_addr));

  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !bus_valid && !rom_valid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !error);
endmodule

bind cfg_cmd_seq cfg_cmd_seq_chk #(.ROM_AW(ROM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
  .rom_valid(rom_valid), .rom_ready(rom_ready), .rom_addr(rom_addr),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata));

// File: tb/cfg_cmd_seq_tb.sv
`timescale 1ns/1ps
module cfg_cmd_seq_tb;
  localparam int AW = 9;
  localparam logic [31:0] RB = 32'h53FD4000;
  localparam logic [31:0] PA = 32'h53FD403C;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, error;
  logic [1:0] err_code;
  logic [15:0] err_off;
  logic rom_valid, rom_ready, bus_valid, bus_ready, bus_write;
  logic [AW-1:0] rom_addr;
  logic [31:0] rom_data, bus_addr, bus_wdata, bus_rdata;
  logic [2:0] bus_size;

  always #4 clk = ~clk;

  cfg_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
    .err_code(err_code), .err_off(err_off), .rom_valid(rom_valid), .rom_ready(rom_ready),
    .rom_addr(rom_addr), .rom_data(rom_data), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  logic [31:0] rom [512];
  int wp;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  assign rom_data  = rom[rom_addr];
  assign rom_ready = (cyc % 4) != 0;
  assign bus_ready = ((cyc / 2) % 3) != 1;

  logic [31:0] regs [16];
  logic        clr, pl_en;
  logic [3:0]  pl_idx;
  logic [31:0] pl_val;
  int          n_tx, poll_cnt, poll_thr;
  logic [31:0] poll_hit, poll_miss;
  logic        lg_wr [64];
  logic [31:0] lg_a [64], lg_d [64];
  logic [2:0]  lg_sz [64];

  function automatic logic is_reg(input logic [31:0] a);
    return (a[31:6] == RB[31:6]) && (a != PA);
  endfunction

  always_comb begin
    if (bus_addr == PA) bus_rdata = (poll_cnt >= poll_thr) ? poll_hit : poll_miss;
    else if (is_reg(bus_addr)) bus_rdata = regs[bus_addr[5:2]];
    else bus_rdata = 32'd0;
  end

  always @(posedge clk) begin
    if (clr) begin
      n_tx <= 0; poll_cnt <= 0;
    end else if (bus_valid && bus_ready) begin
      if (n_tx < 64) begin
        lg_wr[n_tx] <= bus_write; lg_a[n_tx] <= bus_addr; lg_sz[n_tx] <= bus_size;
        lg_d[n_tx]  <= bus_write ? bus_wdata : bus_rdata;
      end
      n_tx <= n_tx + 1;
      if (bus_write && is_reg(bus_addr)) regs[bus_addr[5:2]] <= bus_wdata;
      if (!bus_write && bus_addr == PA) poll_cnt <= poll_cnt + 1;
    end
    if (pl_en) regs[pl_idx] <= pl_val;
  end

  int nchk = 0, nerr = 0;
  logic got_done, got_err, dw_bad, err_at_start;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] be(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic new_tbl();
    for (int i = 0; i < 512; i++) rom[i] = 32'd0;
    wp = 1;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic put(input logic [31:0] v);
    rom[wp] = be(v); wp++;
  endtask

  task automatic seal(input int len_bytes, input logic [7:0] ver);
    rom[0] = be({8'hD2, 16'(len_bytes), ver});
  endtask

  task automatic preload(input logic [3:0] idx, input logic [31:0] v);
    @(negedge clk); pl_en = 1'b1; pl_idx = idx; pl_val = v;
    @(negedge clk); pl_en = 1'b0;
  endtask

  task automatic run();
    got_done = 1'b0; got_err = 1'b0; dw_bad = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; err_at_start = error;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin
        got_done = 1'b1;
        @(negedge clk);
        if (done) dw_bad = 1'b1;
        break;
      end
      if (error) begin got_err = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R10 reset done", {31'd0, done}, 32'd0);
    chk("R10 reset error", {31'd0, error}, 32'd0);
    chk("R11 reset ports idle", {30'd0, rom_valid, bus_valid}, 32'd0);
  endtask

  task automatic t_write();
    new_tbl();
    put(32'hCC001404);
    put(RB + 32'h4); put(32'h11223344);
    put(RB + 32'h8); put(32'hA5A50F0F);
    put(32'hC0000400);
    seal(28, 8'h40);
    run();
    chk("R3 done", {31'd0, got_done}, 32'd1);
    chk("R10 done one cycle", {31'd0, dw_bad}, 32'd0);
    chk("R7 R3 tx count", n_tx, 32'd2);
    chk("R3 tx0 write", {31'd0, lg_wr[0]}, 32'd1);
    chk("R1 R3 tx0 addr", lg_a[0], RB + 32'h4);
    chk("R1 R3 tx0 data", lg_d[0], 32'h11223344);
    chk("R3 tx1 addr", lg_a[1], RB + 32'h8);
    chk("R3 tx1 data", lg_d[1], 32'hA5A50F0F);
    chk("R3 size", {29'd0, lg_sz[1]}, 32'd4);
  endtask

  task automatic t_rmw();
    preload(4'd3, 32'hF0F00000);
    new_tbl();
    put(32'hCC000C1A); put(RB + 32'hC); put(32'h000000FF);
    put(32'hCC000C0A); put(RB + 32'hC); put(32'hF0000000);
    seal(28, 8'h40);
    run();
    chk("R4 done", {31'd0, got_done}, 32'd1);
    chk("R4 tx count", n_tx, 32'd4);
    chk("R4 first is read", {31'd0, lg_wr[0]}, 32'd0);
    chk("R4 set result", lg_d[1], 32'hF0F000FF);
    chk("R4 clear read", lg_d[2], 32'hF0F000FF);
    chk("R4 clear result", lg_d[3], 32'h00F000FF);
    chk("R3 R4 halfword size", {29'd0, lg_sz[3]}, 32'd2);
  endtask

  task automatic t_poll_all_set();
    new_tbl();
    poll_thr = 4; poll_miss = 32'h0000FFFF; poll_hit = 32'h0001FFFF;
    put(32'hCF000C14); put(PA); put(32'h00010000);
    seal(16, 8'h40);
    run();
    chk("R5 all-set done", {31'd0, got_done}, 32'd1);
    chk("R5 all-set polls", n_tx, 32'd5);
  endtask

  task automatic t_poll_any_clr();
    new_tbl();
    poll_thr = 2; poll_miss = 32'h00000003; poll_hit = 32'h00000001;
    put(32'hCF000C0C); put(PA); put(32'h00000003);
    seal(16, 8'h40);
    run();
    chk("R5 any-clear done", {31'd0, got_done}, 32'd1);
    chk("R5 any-clear polls", n_tx, 32'd3);
  endtask

  task automatic t_timeout();
    new_tbl();
    poll_thr = 1000; poll_miss = 32'h0; poll_hit = 32'h0;
    put(32'hC0000400);
    put(32'hCF001014); put(PA); put(32'h00000080); put(32'd3);
    seal(24, 8'h40);
    run();
    chk("R6 timeout error", {31'd0, got_err}, 32'd1);
    chk("R6 timeout code", {30'd0, err_code}, 32'd3);
    chk("R6 timeout offset", {16'd0, err_off}, 32'd8);
    chk("R6 polls used", n_tx, 32'd3);
  endtask

  task automatic t_addr();
    new_tbl();
    put(32'hCC001404);
    put(32'hF8017FF0); put(32'h1);
    put(32'hF8017FF4); put(32'h2);
    seal(24, 8'h40);
    run();
    chk("R8 error", {31'd0, got_err}, 32'd1);
    chk("R8 code", {30'd0, err_code}, 32'd1);
    chk("R8 offset", {16'd0, err_off}, 32'd16);
    chk("R8 legal edge written only", n_tx, 32'd1);
    chk("R8 edge addr", lg_a[0], 32'hF8017FF0);
  endtask

  task automatic t_header();
    new_tbl(); seal(4, 8'h41);
    run();
    chk("R2 bad version code", {30'd0, err_code}, 32'd2);
    chk("R2 bad version offset", {16'd0, err_off}, 32'd0);
    new_tbl(); seal(1772, 8'h40);
    run();
    chk("R10 error cleared by start", {31'd0, err_at_start}, 32'd0);
    chk("R2 too long", {30'd0, err_code}, 32'd2);
    new_tbl(); seal(4, 8'h40);
    run();
    chk("R2 empty table done", {31'd0, got_done}, 32'd1);
    new_tbl();
    for (int i = 0; i < 441; i++) put(32'hC0000400);
    seal(1768, 8'h40);
    run();
    chk("R2 R7 max length done", {31'd0, got_done}, 32'd1);
    chk("R7 no bus access", n_tx, 32'd0);
  endtask

  task automatic t_format();
    new_tbl(); put(32'hAB000400); seal(8, 8'h40);
    run();
    chk("R9 unknown tag code", {30'd0, err_code}, 32'd2);
    chk("R9 unknown tag offset", {16'd0, err_off}, 32'd4);
    new_tbl(); put(32'hC0000400);
    put(32'hCC001404); put(RB); put(32'h5); put(RB); put(32'h6);
    seal(20, 8'h40);
    run();
    chk("R9 overrun code", {30'd0, err_code}, 32'd2);
    chk("R9 overrun offset", {16'd0, err_off}, 32'd8);
    chk("R9 overrun no access", n_tx, 32'd0);
    new_tbl(); put(32'hCC000C14); put(RB); put(32'h7); seal(16, 8'h40);
    run();
    chk("R4 bad op code", {30'd0, err_code}, 32'd2);
    chk("R4 bad op no access", n_tx, 32'd0);
  endtask

  initial begin
    clr = 1'b0; pl_en = 1'b0; pl_idx = 4'd0; pl_val = 32'd0;
    poll_thr = 0; poll_hit = 32'd0; poll_miss = 32'd0;
    for (int i = 0; i < 16; i++) regs[i] = 32'd0;
    for (int i = 0; i < 512; i++) rom[i] = 32'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_write();
    t_rmw();
    t_poll_all_set();
    t_poll_any_clr();
    t_timeout();
    t_addr();
    t_header();
    t_format();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule